// File: doc/BRIEF.md
# Region Attribute Table

This block holds one small attribute record for each 16 MB region of a 32-bit logical address space. Each record carries two flags: whether accesses to the region may be cached, and whether a prefetch engine may run ahead into it. Software sets the flags through a word-wide register port. Cache and prefetch logic present an access address on a separate lookup port and get the flags for that region back in the same cycle.

The region of an address is its top byte, so the table has 256 entries. The lowest sixteen entries cover on-chip memories. They are hardwired to zero and cannot be written. Each 32-bit register stores only two bits. The other thirty bits read as zero and drop whatever is written to them. Registers beyond the 1 KB window read as zero and ignore writes.

Top module: `region_attr_table`

## Requirements
- R1: The lookup port selects entry `lk_addr[31:24]` and drives `lk_cacheable` and `lk_prefetchable` combinationally from that entry, in the same cycle the address is presented.
- R2: In every register word, bit 0 is the cacheable flag and bit 3 is the prefetchable flag. Writing 0x9 sets both, 0x0 clears both, 0x1 sets cacheable only and 0x8 sets prefetchable only.
- R3: Register k sits at byte offset 4*k on `cfg_addr`. `cfg_addr[1:0]` is ignored for both reads and writes.
- R4: Bits other than 0 and 3 always read as zero, and values written to them are discarded.
- R5: Entries 0 to 15 are read-only and always zero. Writes to them change nothing, and lookups whose top byte is 0x00 to 0x0F return both flags low.
- R6: While `rst` is high on a clock edge, every entry is cleared, and `cfg_rdata` is cleared to zero.
- R7: A write to a writable entry on one clock edge is seen by lookups and by register reads from the cycle after that edge.
- R8: Offsets of 0x400 and above are outside the window. Reads there return zero, and writes there change no entry.
- R9: `cfg_rdata` is registered. It updates on the clock edge at which `cfg_rd_en` is sampled high and holds its value until the next read. A read and a write of the same register on the same edge return the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_rd_en | input | 1 | Register read strobe |
| cfg_addr | input | 16 | Byte offset of the register access |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Registered read data |
| lk_addr | input | 32 | Access address to classify |
| lk_cacheable | output | 1 | Region may be cached |
| lk_prefetchable | output | 1 | Region may be prefetched |

## Verification
The bench writes all-ones to protected entries and to an offset beyond the window that aliases a writable entry if the upper offset bits are dropped. A decoder that truncated the offset, or that did not guard the protected range, would corrupt an entry that a later read or lookup exposes. It also writes single-flag patterns, to catch swapped or misplaced flag bits. It covers the two end entries, 16 and 255, and misaligned offsets, which must still land on the right word. Finally, it issues a read together with a write to the same register. A design that forwarded the write data would return the new value instead of the old one.

// File: rtl/region_attr_pkg.sv
package region_attr_pkg;

  localparam int CACHE_POS = 0;
  localparam int PREF_POS  = 3;

  typedef struct packed {
    logic pref;
    logic cache;
  } attr_t;

  function automatic logic [31:0] pack_word(input attr_t a);
    logic [31:0] w;
    w = '0;
    w[CACHE_POS] = a.cache;
    w[PREF_POS]  = a.pref;
    return w;
  endfunction

  function automatic attr_t unpack_word(input logic [31:0] w);
    attr_t a;
    a.cache = w[CACHE_POS];
    a.pref  = w[PREF_POS];
    return a;
  endfunction

endpackage

// File: rtl/region_attr_decode.sv
module region_attr_decode #(
  parameter int CFG_ADDR_W = 16,
  parameter int IDX_W      = 8,
  parameter int RO_COUNT   = 16
) (
  input  logic [CFG_ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]      idx,
  output logic                  in_window,
  output logic                  writable
);

  localparam int WORD_LSB = 2;
  localparam int TOP_LSB  = IDX_W + WORD_LSB;

  assign idx = addr[TOP_LSB-1:WORD_LSB];

  generate
    if (CFG_ADDR_W > TOP_LSB) begin : g_upper
      assign in_window = (addr[CFG_ADDR_W-1:TOP_LSB] == '0);
    end else begin : g_full
      assign in_window = 1'b1;
    end
  endgenerate

  assign writable = in_window && (int'(idx) >= RO_COUNT);

endmodule

// File: rtl/region_attr_bank.sv
module region_attr_bank
  import region_attr_pkg::*;
#(
  parameter int IDX_W    = 8,
  parameter int RO_COUNT = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  attr_t                 wr_attr,
  output logic [(1<<IDX_W)-1:0] cache_vec,
  output logic [(1<<IDX_W)-1:0] pref_vec
);

  localparam int ENTRIES = 1 << IDX_W;

  logic [ENTRIES-1:0] cache_q;
  logic [ENTRIES-1:0] pref_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cache_q <= '0;
      pref_q  <= '0;
    end else if (wr_en) begin
      cache_q[wr_idx] <= wr_attr.cache;
      pref_q[wr_idx]  <= wr_attr.pref;
    end
  end

  for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
    if (i < RO_COUNT) begin : g_ro
      assign cache_vec[i] = 1'b0;
      assign pref_vec[i]  = 1'b0;
    end else begin : g_rw
      assign cache_vec[i] = cache_q[i];
      assign pref_vec[i]  = pref_q[i];
    end
  end

endmodule

// File: rtl/region_attr_lookup.sv
module region_attr_lookup #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 8
) (
  input  logic [ADDR_W-1:0]     addr,
  input  logic [(1<<IDX_W)-1:0] cache_vec,
  input  logic [(1<<IDX_W)-1:0] pref_vec,
  output logic                  cacheable,
  output logic                  prefetchable
);

  logic [IDX_W-1:0] region;

  assign region       = addr[ADDR_W-1 -: IDX_W];
  assign cacheable    = cache_vec[region];
  assign prefetchable = pref_vec[region];

endmodule

// File: rtl/region_attr_table.sv
module region_attr_table
  import region_attr_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int REGION_SHIFT = 24,
  parameter int CFG_ADDR_W   = 16,
  parameter int RO_COUNT     = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cfg_wr_en,
  input  logic                  cfg_rd_en,
  input  logic [CFG_ADDR_W-1:0] cfg_addr,
  input  logic [31:0]           cfg_wdata,
  output logic [31:0]           cfg_rdata,
  input  logic [ADDR_W-1:0]     lk_addr,
  output logic                  lk_cacheable,
  output logic                  lk_prefetchable
);

  localparam int IDX_W   = ADDR_W - REGION_SHIFT;
  localparam int ENTRIES = 1 << IDX_W;

  logic [IDX_W-1:0]   acc_idx;
  logic               acc_in_window;
  logic               acc_writable;
  logic [ENTRIES-1:0] cache_vec;
  logic [ENTRIES-1:0] pref_vec;
  attr_t              rd_attr;

  region_attr_decode #(
    .CFG_ADDR_W(CFG_ADDR_W),
    .IDX_W     (IDX_W),
    .RO_COUNT  (RO_COUNT)
  ) u_decode (
    .addr     (cfg_addr),
    .idx      (acc_idx),
    .in_window(acc_in_window),
    .writable (acc_writable)
  );

  region_attr_bank #(
    .IDX_W   (IDX_W),
    .RO_COUNT(RO_COUNT)
  ) u_bank (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (cfg_wr_en && acc_writable),
    .wr_idx   (acc_idx),
    .wr_attr  (unpack_word(cfg_wdata)),
    .cache_vec(cache_vec),
    .pref_vec (pref_vec)
  );

  region_attr_lookup #(
    .ADDR_W(ADDR_W),
    .IDX_W (IDX_W)
  ) u_lookup (
    .addr        (lk_addr),
    .cache_vec   (cache_vec),
    .pref_vec    (pref_vec),
    .cacheable   (lk_cacheable),
    .prefetchable(lk_prefetchable)
  );

  always_comb begin
    rd_attr.cache = cache_vec[acc_idx] & acc_in_window;
    rd_attr.pref  = pref_vec[acc_idx] & acc_in_window;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_rdata <= '0;
    end else if (cfg_rd_en) begin
      cfg_rdata <= pack_word(rd_attr);
    end
  end

endmodule

// File: rtl/region_attr_checker.sv
module region_attr_checker #(
  parameter int ADDR_W     = 32,
  parameter int IDX_W      = 8,
  parameter int CFG_ADDR_W = 16,
  parameter int RO_COUNT   = 16
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  cfg_wr_en,
  input logic                  cfg_rd_en,
  input logic [CFG_ADDR_W-1:0] cfg_addr,
  input logic [31:0]           cfg_wdata,
  input logic [31:0]           cfg_rdata,
  input logic [ADDR_W-1:0]     lk_addr,
  input logic                  lk_cacheable,
  input logic                  lk_prefetchable,
  input logic [(1<<IDX_W)-1:0] cache_vec,
  input logic [(1<<IDX_W)-1:0] pref_vec
);

  localparam int WIN_BYTES = (1 << IDX_W) * 4;

  logic             ok_wr;
  logic             out_rd;
  logic             seen_wr;
  logic [IDX_W-1:0] seen_idx;
  logic             seen_c;
  logic             seen_p;

  assign ok_wr  = cfg_wr_en && (int'(cfg_addr) < WIN_BYTES) &&
                  (int'(cfg_addr) / 4 >= RO_COUNT);
  assign out_rd = cfg_rd_en && (int'(cfg_addr) >= WIN_BYTES);

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_wr  <= 1'b0;
      seen_idx <= '0;
      seen_c   <= 1'b0;
      seen_p   <= 1'b0;
    end else begin
      seen_wr  <= ok_wr;
      seen_idx <= IDX_W'(int'(cfg_addr) / 4);
      seen_c   <= cfg_wdata[0];
      seen_p   <= cfg_wdata[3];
    end
  end

  // R7: an accepted write shows up in the entry one cycle later
  p_write_lands_r7: assert property (@(posedge clk) disable iff (rst)
    seen_wr |-> (cache_vec[seen_idx] == seen_c) && (pref_vec[seen_idx] == seen_p));

  // R4: reserved read-data bits stay low
  p_reserved_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (cfg_rdata & ~32'h0000_0009) == 32'h0);

  // R5: protected regions always report no attributes
  p_ro_region_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (int'(lk_addr[ADDR_W-1 -: IDX_W]) < RO_COUNT) |-> (!lk_cacheable && !lk_prefetchable));

  // R8: reads outside the window return zero
  p_oob_read_zero_r8: assert property (@(posedge clk) disable iff (rst)
    out_rd |=> (cfg_rdata == 32'h0));

  // R9: read data holds between reads
  p_rdata_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !cfg_rd_en |=> $stable(cfg_rdata));

  // R8: a cycle without an accepted write leaves every entry untouched
  p_no_stray_write_r8: assert property (@(posedge clk) disable iff (rst)
    !ok_wr |=> ($stable(cache_vec) && $stable(pref_vec)));

endmodule

bind region_attr_table region_attr_checker #(
  .ADDR_W    (ADDR_W),
  .IDX_W     (IDX_W),
  .CFG_ADDR_W(CFG_ADDR_W),
  .RO_COUNT  (RO_COUNT)
) u_checker (
  .clk            (clk),
  .rst            (rst),
  .cfg_wr_en      (cfg_wr_en),
  .cfg_rd_en      (cfg_rd_en),
  .cfg_addr       (cfg_addr),
  .cfg_wdata      (cfg_wdata),
  .cfg_rdata      (cfg_rdata),
  .lk_addr        (lk_addr),
  .lk_cacheable   (lk_cacheable),
  .lk_prefetchable(lk_prefetchable),
  .cache_vec      (cache_vec),
  .pref_vec       (pref_vec)
);

// File: tb/tb_region_attr_table.sv
module tb_region_attr_table;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr_en = 1'b0;
  logic        cfg_rd_en = 1'b0;
  logic [15:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [31:0] lk_addr = '0;
  logic        lk_cacheable;
  logic        lk_prefetchable;

  int n_tests = 0;
  int n_fail  = 0;
  bit exp_c [256];
  bit exp_p [256];
  bit done = 1'b0;

  always #5 clk = ~clk;

  region_attr_table dut (
    .clk            (clk),
    .rst            (rst),
    .cfg_wr_en      (cfg_wr_en),
    .cfg_rd_en      (cfg_rd_en),
    .cfg_addr       (cfg_addr),
    .cfg_wdata      (cfg_wdata),
    .cfg_rdata      (cfg_rdata),
    .lk_addr        (lk_addr),
    .lk_cacheable   (lk_cacheable),
    .lk_prefetchable(lk_prefetchable)
  );

  function automatic logic [31:0] exp_word(input int off);
    int k;
    if (off >= 1024) return 32'h0;
    k = off / 4;
    return {28'h0, exp_p[k], 2'b00, exp_c[k]};
  endfunction

  function automatic void model_write(input int off, input logic [31:0] d);
    int k;
    if (off >= 1024) return;
    k = off / 4;
    if (k < 16) return;
    exp_c[k] = d[0];
    exp_p[k] = d[3];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(input int off, input logic [31:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1;
    cfg_addr  = 16'(off);
    cfg_wdata = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
    model_write(off, d);
  endtask

  task automatic read_check(input string req, input int off);
    @(negedge clk);
    cfg_rd_en = 1'b1;
    cfg_addr  = 16'(off);
    @(negedge clk);
    cfg_rd_en = 1'b0;
    check(req, cfg_rdata, exp_word(off & ~3));
  endtask

  task automatic lookup_check(input string req, input logic [31:0] a);
    int k;
    k = int'(a[31:24]);
    lk_addr = a;
    #1;
    check(req, {30'h0, lk_prefetchable, lk_cacheable}, {30'h0, exp_p[k], exp_c[k]});
  endtask

  initial begin
    #1500000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int seed;
    logic [31:0] rv;
    for (int i = 0; i < 256; i++) begin
      exp_c[i] = 1'b0;
      exp_p[i] = 1'b0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R6: reset state
    check("R6 rdata", cfg_rdata, 32'h0);
    lookup_check("R6 lookup", 32'hE000_0000);
    read_check("R6 read", 32'h380);

    // R2/R3: enable both on region 0xE0 at offset 0x380
    do_write(32'h380, 32'h9);
    lookup_check("R2 both", 32'hE012_3456);
    read_check("R3 offset 0x380", 32'h380);

    // R2: single flags
    do_write(17 * 4, 32'h1);
    lookup_check("R2 cache only", 32'h11FF_FFFF);
    do_write(18 * 4, 32'h8);
    lookup_check("R2 pref only", 32'h1200_0000);
    do_write(32'h380, 32'h0);
    lookup_check("R2 clear", 32'hE000_0000);

    // R4: reserved bits
    do_write(16 * 4, 32'hFFFF_FFFF);
    read_check("R4 reserved masked", 16 * 4);
    do_write(16 * 4, 32'hFFFF_FFF6);
    read_check("R4 only reserved", 16 * 4);

    // R5: protected entries
    do_write(5 * 4, 32'hFFFF_FFFF);
    read_check("R5 ro read", 5 * 4);
    lookup_check("R5 ro lookup", 32'h0500_0000);
    do_write(15 * 4, 32'h9);
    lookup_check("R5 entry 15", 32'h0F00_0000);

    // R3: top entry and misaligned offset
    do_write(255 * 4 + 3, 32'h9);
    lookup_check("R3 entry 255", 32'hFFFF_FFFF);
    read_check("R3 misaligned", 255 * 4 + 1);

    // R8: outside window
    do_write(32'h440, 32'h9);
    read_check("R8 alias untouched", 32'h040);
    read_check("R8 oob read", 32'h440);
    read_check("R8 oob read high", 32'hFFFC);

    // R7: write visible on next cycle to lookup
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_addr = 16'(40 * 4); cfg_wdata = 32'h9;
    lk_addr = 32'h2800_0000;
    @(posedge clk); #1;
    cfg_wr_en = 1'b0;
    model_write(40 * 4, 32'h9);
    check("R7 next cycle", {30'h0, lk_prefetchable, lk_cacheable}, 32'h3);

    // R9: read with same-edge write returns old value, then holds
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_rd_en = 1'b1; cfg_addr = 16'(40 * 4); cfg_wdata = 32'h0;
    @(negedge clk);
    cfg_wr_en = 1'b0; cfg_rd_en = 1'b0;
    check("R9 read before write", cfg_rdata, 32'h9);
    model_write(40 * 4, 32'h0);
    @(negedge clk);
    check("R9 hold", cfg_rdata, 32'h9);
    read_check("R9 after write", 40 * 4);

    // R1: lookup per region, random phase
    seed = $urandom(32'd20240611);
    for (int it = 0; it < 400; it++) begin
      int off;
      off = int'($urandom_range(0, 1279));
      rv  = $urandom;
      do_write(off, rv);
      read_check("R3 random read", int'($urandom_range(0, 1279)));
      lookup_check("R1 random lookup", $urandom);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule